// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer

This block is a small fully associative translation buffer that maps virtual page numbers to physical page numbers. Every entry is either tagged with the context identifier that was current when it was filled, or marked global. A tagged entry answers a lookup only while its identifier equals the current context identifier, so tagged entries stay resident across context switches and come back into use when their context is resumed. Global entries answer under every context, but all of them are dropped on each context switch.

One lookup is served per cycle. Hit, miss and physical page number come back combinationally in the same cycle, so the lookup can run alongside a cache access whose result only needs the translation on a miss. A miss is the cue for an external page walker, which writes the translation back through the fill port. A fill takes the lowest-numbered invalid entry. If every entry is valid, it takes the entry under a round-robin pointer. The two victim sources are named PICK_FREE and PICK_ROUND.

Context control has two commands. A switch loads a new current identifier and clears every global valid bit in the same cycle. A flush by identifier drops only the tagged entries that carry that identifier, for use when the identifier is handed to a new process. When an invalidation and a fill arrive in the same cycle, the invalidation is applied first and the fill is written on top of it.

Top module: `ctx_tlb`

## Requirements
- R1: After reset every entry is invalid, the current identifier `cur_cid` is 0, and every lookup misses.
- R2: A valid tagged entry hits only when its stored identifier equals `cur_cid`. Its physical page number appears on `lk_ppn` in the same cycle as the lookup.
- R3: A valid global entry (filled with `fill_global` = 1) hits for a matching page number whatever the value of `cur_cid`.
- R4: When `sw_valid` is high, `cur_cid` takes `sw_cid` at the next edge and every global entry becomes invalid. Tagged entries of any identifier are kept.
- R5: When `fl_valid` is high, every tagged entry whose identifier equals `fl_cid` becomes invalid. Global entries and tagged entries of other identifiers are untouched.
- R6: `lk_hit` = `lk_valid` AND a matching entry exists, and `lk_miss` = `lk_valid` AND no matching entry exists. Both are low when `lk_valid` is low.
- R7: A fill writes the lowest-indexed entry that is invalid after the same cycle's invalidations. If no entry is invalid, it writes the entry at a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping after the last entry, on each fill that uses it.
- R8: A flush or switch in the same cycle as a fill is applied first, so the newly filled entry is valid afterwards, even a global one filled in a switch cycle.
- R9: A tagged fill stores the value `cur_cid` holds in the fill cycle, before any switch in that cycle takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Lookup found a usable entry |
| lk_miss | output | 1 | Lookup found no usable entry; walker should service it |
| lk_ppn | output | PPN_W | Physical page number; meaningful when `lk_hit` is 1 |
| fill_valid | input | 1 | Write a translation from the page walker |
| fill_vpn | input | VPN_W | Virtual page number of the fill |
| fill_ppn | input | PPN_W | Physical page number of the fill |
| fill_global | input | 1 | 1 = global entry, 0 = tagged with the current identifier |
| sw_valid | input | 1 | Context switch strobe |
| sw_cid | input | CID_W | Identifier of the incoming context |
| fl_valid | input | 1 | Flush-by-identifier strobe |
| fl_cid | input | CID_W | Identifier whose tagged entries are dropped |
| cur_cid | output | CID_W | Current context identifier |

## Verification
The bench targets four kinds of corner case. The first is a context switch away and back: a design that flushed tagged entries on a switch would miss on return, and one that kept globals would hit stale translations. The second is the same-cycle pairs of switch with global fill and flush with fill of the flushed identifier: a design that ordered them the wrong way would lose the fresh entry. The third is a full table: a wrong round-robin pointer, or one that advances on fills into free entries, evicts the wrong translation and shows up as an unexpected miss or hit. The fourth is a long random mix of lookups, fills, switches and flushes over a small page and identifier pool, which catches identifier comparisons that ignore the global bit or tag fills with the incoming identifier.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;

    // Source of the entry chosen for a fill.
    typedef enum logic [0:0] {
        PICK_FREE  = 1'b0,
        PICK_ROUND = 1'b1
    } pick_e;

endpackage

// File: rtl/ctx_tlb_match.sv
module ctx_tlb_match #(
    parameter int N     = 8,
    parameter int VPN_W = 20,
    parameter int PPN_W = 16,
    parameter int CID_W = 8
) (
    input  logic [N-1:0]             ent_valid,
    input  logic [N-1:0]             ent_glob,
    input  logic [N-1:0][VPN_W-1:0]  ent_vpn,
    input  logic [N-1:0][PPN_W-1:0]  ent_ppn,
    input  logic [N-1:0][CID_W-1:0]  ent_cid,
    input  logic [CID_W-1:0]         cur_cid,
    input  logic [VPN_W-1:0]         q_vpn,
    output logic [N-1:0]             hit_vec,
    output logic                     any_hit,
    output logic [PPN_W-1:0]         hit_ppn
);

    // R2 R3: per-entry compare, identifier ignored for global entries
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_vec[i] = ent_valid[i] && (ent_vpn[i] == q_vpn) &&
                            (ent_glob[i] || (ent_cid[i] == cur_cid));
    end

    assign any_hit = |hit_vec;

    always_comb begin
        hit_ppn = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) begin
                hit_ppn = hit_ppn | ent_ppn[i];
            end
        end
    end

endmodule

// File: rtl/ctx_tlb_victim.sv
module ctx_tlb_victim
    import ctx_tlb_pkg::*;
#(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     avail_valid,
    input  logic             take,
    output logic [IDX_W-1:0] vic_idx,
    output pick_e            vic_pick
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             free_any;

    // R7: lowest invalid entry wins
    always_comb begin
        free_idx = '0;
        free_any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!avail_valid[i]) begin
                free_idx = IDX_W'(i);
                free_any = 1'b1;
            end
        end
    end

    always_comb begin
        vic_pick = free_any ? PICK_FREE : PICK_ROUND;
        unique case (vic_pick)
            PICK_FREE:  vic_idx = free_idx;
            PICK_ROUND: vic_idx = rr_q;
            default:    vic_idx = rr_q;
        endcase
    end

    // R7: pointer moves only when it supplied the victim
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (take && (vic_pick == PICK_ROUND)) begin
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end

    // R7
    // rr_step_chk: a round-robin fill moves the pointer by exactly one place
    rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && vic_pick == PICK_ROUND) |=>
            (rr_q == (($past(rr_q) == LAST) ? '0 : $past(rr_q) + 1'b1)));

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
    import ctx_tlb_pkg::*;
#(
    parameter int N     = 8,
    parameter int VPN_W = 20,
    parameter int PPN_W = 16,
    parameter int CID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_global,
    input  logic             sw_valid,
    input  logic [CID_W-1:0] sw_cid,
    input  logic             fl_valid,
    input  logic [CID_W-1:0] fl_cid,
    output logic [CID_W-1:0] cur_cid
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]            v_q;
    logic [N-1:0]            g_q;
    logic [N-1:0][VPN_W-1:0] vpn_q;
    logic [N-1:0][PPN_W-1:0] ppn_q;
    logic [N-1:0][CID_W-1:0] cid_q;
    logic [CID_W-1:0]        cur_q;

    logic [N-1:0]            keep_v;
    logic [N-1:0]            hit_vec;
    logic                    any_hit;
    logic [PPN_W-1:0]        hit_ppn;
    logic [IDX_W-1:0]        vic_idx;
    pick_e                   vic_pick;

    ctx_tlb_match #(
        .N(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .CID_W(CID_W)
    ) u_match (
        .ent_valid (v_q),
        .ent_glob  (g_q),
        .ent_vpn   (vpn_q),
        .ent_ppn   (ppn_q),
        .ent_cid   (cid_q),
        .cur_cid   (cur_q),
        .q_vpn     (lk_vpn),
        .hit_vec   (hit_vec),
        .any_hit   (any_hit),
        .hit_ppn   (hit_ppn)
    );

    // R6: lookup result in the request cycle
    assign lk_hit  = lk_valid && any_hit;
    assign lk_miss = lk_valid && !any_hit;
    assign lk_ppn  = hit_ppn;
    assign cur_cid = cur_q;

    // R4 R5 R8: invalidations form the base the fill is written over
    always_comb begin
        keep_v = v_q;
        for (int i = 0; i < N; i++) begin
            if (sw_valid && g_q[i]) begin
                keep_v[i] = 1'b0;
            end
            if (fl_valid && !g_q[i] && (cid_q[i] == fl_cid)) begin
                keep_v[i] = 1'b0;
            end
        end
    end

    ctx_tlb_victim #(.N(N)) u_victim (
        .clk         (clk),
        .rst_n       (rst_n),
        .avail_valid (keep_v),
        .take        (fill_valid),
        .vic_idx     (vic_idx),
        .vic_pick    (vic_pick)
    );

    // R1 R4 R8: valid, global and context state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q   <= '0;
            g_q   <= '0;
            cur_q <= '0;
        end else begin
            v_q <= keep_v;
            if (fill_valid) begin
                v_q[vic_idx] <= 1'b1;
                g_q[vic_idx] <= fill_global;
            end
            if (sw_valid) begin
                cur_q <= sw_cid;
            end
        end
    end

    // R9: payload written with the identifier held before this edge
    always_ff @(posedge clk) begin
        if (fill_valid) begin
            vpn_q[vic_idx] <= fill_vpn;
            ppn_q[vic_idx] <= fill_ppn;
            cid_q[vic_idx] <= cur_q;
        end
    end

    // Checking state: identifier of the previous cycle's flush
    logic [CID_W-1:0] fl_cid_d;
    logic [N-1:0]     stale_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_cid_d <= '0;
        end else begin
            fl_cid_d <= fl_cid;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_stale
        assign stale_vec[i] = v_q[i] && !g_q[i] && (cid_q[i] == fl_cid_d);
    end

    // R6
    // hit_miss_excl_chk: hit and miss never together, silent when idle
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss) && (lk_valid || (!lk_hit && !lk_miss)));

    // R4
    // ctx_load_chk: the switch identifier is current one cycle later
    ctx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_valid |=> (cur_cid == $past(sw_cid)));

    // R4
    // glob_drop_chk: no global entry survives a switch without a global fill
    glob_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_valid && !(fill_valid && fill_global)) |=> ((v_q & g_q) == '0));

    // R5
    // flush_drop_chk: no tagged entry of the flushed identifier remains
    flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && !fill_valid) |=> (stale_vec == '0));

    // R7
    // free_fill_chk: a fill into a free slot adds exactly one valid entry
    free_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !sw_valid && !fl_valid && (v_q != '1)) |=>
            ($countones(v_q) == $past($countones(v_q)) + 1));

    // R7
    // full_fill_chk: replacing into a full table keeps it full
    full_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !sw_valid && !fl_valid && (v_q == '1)) |=> (v_q == '1));

endmodule

// File: tb/sim_ctx_tlb.sv
module sim_ctx_tlb;

    localparam int N     = 8;
    localparam int VPN_W = 20;
    localparam int PPN_W = 16;
    localparam int CID_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_valid = 1'b0;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic             lk_hit;
    logic             lk_miss;
    logic [PPN_W-1:0] lk_ppn;
    logic             fill_valid = 1'b0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic             fill_global = 1'b0;
    logic             sw_valid = 1'b0;
    logic [CID_W-1:0] sw_cid = '0;
    logic             fl_valid = 1'b0;
    logic [CID_W-1:0] fl_cid = '0;
    logic [CID_W-1:0] cur_cid;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string req = "R1";

    always #4 clk = ~clk;

    ctx_tlb #(.N(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .CID_W(CID_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit),
        .lk_miss(lk_miss), .lk_ppn(lk_ppn),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_global(fill_global),
        .sw_valid(sw_valid), .sw_cid(sw_cid),
        .fl_valid(fl_valid), .fl_cid(fl_cid),
        .cur_cid(cur_cid)
    );

    // Behavioural reference: flat arrays of translations
    bit m_v   [N];
    bit m_g   [N];
    int m_vpn [N];
    int m_ppn [N];
    int m_cid [N];
    int m_rr;
    int m_cur;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_v[i] = 0;
                m_g[i] = 0;
            end
            m_rr  = 0;
            m_cur = 0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (sw_valid && m_g[i]) m_v[i] = 0;
                if (fl_valid && !m_g[i] && m_cid[i] == int'(fl_cid)) m_v[i] = 0;
            end
            if (fill_valid) begin
                int slot;
                slot = -1;
                for (int i = 0; i < N; i++) begin
                    if (slot < 0 && !m_v[i]) slot = i;
                end
                if (slot < 0) begin
                    slot = m_rr;
                    m_rr = (m_rr + 1) % N;
                end
                m_v[slot]   = 1;
                m_g[slot]   = fill_global;
                m_vpn[slot] = int'(fill_vpn);
                m_ppn[slot] = int'(fill_ppn);
                m_cid[slot] = m_cur;
            end
            if (sw_valid) m_cur = int'(sw_cid);
        end
    end

    function automatic bit m_present(input int vpn);
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && m_vpn[i] == vpn) return 1;
        end
        return 0;
    endfunction

    task automatic check();
        bit h;
        int p;
        h = 0;
        p = 0;
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && m_vpn[i] == int'(lk_vpn) && (m_g[i] || m_cid[i] == m_cur)) begin
                h = 1;
                p = m_ppn[i];
            end
        end
        checks++;
        if (int'(cur_cid) != m_cur) begin
            fails++;
            $display("FAIL %s cur_cid got %0d expected %0d", req, cur_cid, m_cur);
        end
        checks++;
        if (lk_hit != (lk_valid && h) || lk_miss != (lk_valid && !h)) begin
            fails++;
            $display("FAIL %s/R6 vpn %0d hit/miss got %0b/%0b expected %0b/%0b",
                     req, lk_vpn, lk_hit, lk_miss, lk_valid && h, lk_valid && !h);
        end
        if (lk_valid && h) begin
            checks++;
            if (int'(lk_ppn) != p) begin
                fails++;
                $display("FAIL %s/R2 vpn %0d ppn got %0d expected %0d", req, lk_vpn, lk_ppn, p);
            end
        end
    endtask

    // Compare in the current cycle, then move to the next one
    task automatic tick();
        #1;
        check();
        @(negedge clk);
        fill_valid = 1'b0;
        sw_valid   = 1'b0;
        fl_valid   = 1'b0;
        lk_valid   = 1'b0;
    endtask

    task automatic look(input int vpn);
        lk_valid = 1'b1;
        lk_vpn   = VPN_W'(vpn);
        tick();
    endtask

    task automatic fill(input int vpn, input int ppn, input bit glob);
        fill_valid  = 1'b1;
        fill_vpn    = VPN_W'(vpn);
        fill_ppn    = PPN_W'(ppn);
        fill_global = glob;
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        req = "R1";
        look(10);
        look(0);

        // R2 R3 R9: tagged entries under identifier 0, one global
        req = "R2";
        fill(10, 100, 0); tick();
        fill(11, 110, 0); tick();
        fill(12, 120, 0); tick();
        req = "R3";
        fill(20, 200, 1); tick();
        look(10); look(11); look(12); look(20);

        // R4: switch to 5, globals dropped, tagged ones hidden
        req = "R4";
        sw_valid = 1'b1; sw_cid = 8'd5; tick();
        look(10); look(20);
        req = "R9";
        fill(10, 150, 0); tick();
        look(10);
        req = "R3";
        fill(21, 210, 1); tick();
        sw_valid = 1'b1; sw_cid = 8'd0;
        lk_valid = 1'b1; lk_vpn = 21;
        tick();
        req = "R4";
        look(10); look(11); look(21);

        // R5: flush identifier 5 from context 0, then return to 5
        req = "R5";
        fill(30, 300, 1); tick();
        fl_valid = 1'b1; fl_cid = 8'd5; tick();
        look(11); look(30);
        sw_valid = 1'b1; sw_cid = 8'd5; tick();
        look(10); look(11);
        sw_valid = 1'b1; sw_cid = 8'd0; tick();
        look(11); look(12);

        // R7: fill to full, then round-robin replacement
        req = "R7";
        for (int k = 0; k < 10; k++) begin
            fill(40 + k, 400 + k, 0); tick();
        end
        for (int k = 10; k <= 12; k++) look(k);
        for (int k = 0; k < 10; k++) look(40 + k);

        // R8: flush of the current identifier together with a fill
        req = "R8";
        fl_valid = 1'b1; fl_cid = 8'd0;
        fill(60, 600, 0); tick();
        look(60); look(40);
        sw_valid = 1'b1; sw_cid = 8'd3;
        fill(61, 610, 1); tick();
        look(61);
        sw_valid = 1'b1; sw_cid = 8'd4;
        fill(62, 620, 0); tick();
        look(62);
        sw_valid = 1'b1; sw_cid = 8'd3; tick();
        req = "R9";
        look(62);

        // R6: idle lookups assert nothing
        req = "R6";
        lk_valid = 1'b0; lk_vpn = 62; tick();

        // Random mix over a small pool
        req = "R2";
        for (int n = 0; n < 3000; n++) begin
            int r;
            int v;
            r = int'($urandom_range(0, 99));
            v = int'($urandom_range(0, 23));
            lk_valid = ($urandom_range(0, 3) != 0);
            lk_vpn   = VPN_W'($urandom_range(0, 23));
            if (r < 35 && !m_present(v)) begin
                fill(v, int'($urandom_range(0, 65535)), ($urandom_range(0, 4) == 0));
            end
            if (r >= 35 && r < 45) begin
                sw_valid = 1'b1;
                sw_cid   = CID_W'($urandom_range(0, 3));
            end
            if (r >= 45 && r < 52) begin
                fl_valid = 1'b1;
                fl_cid   = CID_W'($urandom_range(0, 3));
            end
            tick();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            fails++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule